// File: doc/BRIEF.md
# Accumulator CPU Core

This block is a small processor built around a single 16-bit accumulator. Programs and data share a 4096-word, word-addressed memory that lives inside the block. A testbench or loader fills that memory through a preload port while reset is held. When reset is released, the core starts at a parameterised program address and runs. It repeats a fetch, decode and execute loop that a hardwired state machine steps through.

Every internal register has a numeric location on a shared internal bus. Each micro-step picks one source location and at most one destination location. The accumulator can also be updated by a four-function ALU: add, subtract, clear and no-operation. A step counter numbers the execute micro-steps. It is cleared whenever an instruction completes.

Byte-wide input uses a valid/ready handshake that the core polls. Byte-wide output pulses a strobe. Execution stops at a halt instruction.

The control machine has five states:
- FETCH_A moves the PC onto the bus and into the MAR.
- FETCH_B loads the IR from memory and advances the PC.
- DECODE copies the IR's address field into the MAR.
- EXEC runs the numbered micro-steps of the opcode.
- HALT is terminal.

Its transitions are:
- FETCH_A always goes to FETCH_B, FETCH_B to DECODE, and DECODE to EXEC.
- EXEC returns to FETCH_A when the instruction is done.
- EXEC goes to HALT on the halt opcode.
- EXEC stays in EXEC while more micro-steps remain or while input is awaited.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low the PC holds START_PC (default 0x100), the accumulator is zero, and `halted`, `out_valid` and `in_ready` are low. Words presented on the preload port are written into memory only during that time.
- R2: An instruction word has its opcode in bits 15:12 and an operand address X in bits 11:0. Opcode 1 copies M[X] into the accumulator. Opcode 2 writes the accumulator into M[X].
- R3: Opcode 3 adds M[X] to the accumulator and opcode 4 subtracts it. Both wrap modulo 2^16 in two's complement.
- R4: Opcode 8 skips the next instruction when its condition holds. Bits 11:10 of the instruction select the condition: 00 means accumulator negative, 01 means zero, 10 means positive, and 11 never skips.
- R5: Opcode 9 sets the PC to X. Opcodes 0xD, 0xE and 0xF change nothing except the PC advance of their fetch.
- R6: Opcode 0 stores the address of the following instruction into M[X] and continues at X+1. Opcode 0xC continues at the address held in M[X] bits 11:0.
- R7: Opcode 0xB adds M[M[X]] (pointer in bits 11:0) to the accumulator.
- R8: Opcode 0xA sets the accumulator to zero.
- R9: Opcode 5 raises `in_ready` and waits with the accumulator unchanged until `in_valid` is seen. It then loads the accumulator with `in_data` zero-extended.
- R10: Opcode 6 copies accumulator bits 7:0 to `out_data`, with `out_valid` high for exactly one cycle.
- R11: Opcode 7 raises `halted`. From then on the PC and accumulator stay frozen and no output strobe occurs.
- R12: The PC advances by one on each fetch and wraps from 0xFFF to 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; preload window |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 12 | Preload word address |
| pl_data | input | 16 | Preload word |
| in_valid | input | 1 | Input byte available |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Core is waiting in an input instruction |
| out_valid | output | 1 | One-cycle strobe for a new output byte |
| out_data | output | 8 | Output register |
| halted | output | 1 | Halt reached |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |

## Verification
The arithmetic vectors target signed overflow (0x7FFF+1), borrow below zero, and the case where a store followed by a reload exposes a lost memory write. A wrong adder or a dropped write would return the wrong sum after the reload.

Each skip condition code is paired with accumulator values on both sides of zero. A mis-decoded condition field would let the guarded load run, or block it, and show up in the final accumulator.

Subroutine entry and return through the stored link check that the saved address is the one after the call. An off-by-one would repeat the call or skip the output.

The input wait must hold the accumulator until the handshake completes. A jump to 0xFFF must wrap the PC to 0x000. A halted core must stay frozen.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int WORD_W = 16;
    localparam int MEM_AW = 12;
    localparam int BYTE_W = 8;
    localparam int STEP_W = 3;

    typedef enum logic [3:0] {
        OP_JNS    = 4'h0,
        OP_LOAD   = 4'h1,
        OP_STORE  = 4'h2,
        OP_ADD    = 4'h3,
        OP_SUBT   = 4'h4,
        OP_INPUT  = 4'h5,
        OP_OUTPUT = 4'h6,
        OP_HALT   = 4'h7,
        OP_SKIP   = 4'h8,
        OP_JUMP   = 4'h9,
        OP_CLEAR  = 4'hA,
        OP_ADDI   = 4'hB,
        OP_JUMPI  = 4'hC,
        OP_IDLE_D = 4'hD,
        OP_IDLE_E = 4'hE,
        OP_IDLE_F = 4'hF
    } opcode_e;

    // bus locations: read code drives the bus, write code captures it
    typedef enum logic [2:0] {
        LOC_MEM = 3'd0,
        LOC_MAR = 3'd1,
        LOC_PC  = 3'd2,
        LOC_MBR = 3'd3,
        LOC_AC  = 3'd4,
        LOC_IN  = 3'd5,
        LOC_OUT = 3'd6,
        LOC_IR  = 3'd7
    } loc_e;

    typedef enum logic [1:0] {
        ALU_NOP = 2'd0,
        ALU_ADD = 2'd1,
        ALU_SUB = 2'd2,
        ALU_CLR = 2'd3
    } alu_op_e;

    typedef enum logic [2:0] {
        ST_FETCH_A = 3'd0,
        ST_FETCH_B = 3'd1,
        ST_DECODE  = 3'd2,
        ST_EXEC    = 3'd3,
        ST_HALT    = 3'd4
    } state_e;

    typedef struct packed {
        loc_e    src;
        loc_e    dst;
        logic    dst_en;
        alu_op_e alu;
        logic    pc_inc;
        logic    in_rdy;
    } ctl_t;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu import acc_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_CLR: y = '0;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl import acc_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] op_field,
    input  logic [1:0] cond_field,
    input  logic       ac_neg,
    input  logic       ac_zero,
    input  logic       in_valid,
    output ctl_t       ctl,
    output logic       halted
);
    localparam logic [STEP_W-1:0] K0 = STEP_W'(0);
    localparam logic [STEP_W-1:0] K1 = STEP_W'(1);
    localparam logic [STEP_W-1:0] K2 = STEP_W'(2);

    state_e            state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              done, go_halt, hold;
    logic              skip_hit;
    opcode_e           opc;

    assign opc = opcode_e'(op_field);

    function automatic ctl_t xfer(loc_e s, loc_e d);
        ctl_t c;
        c        = '0;
        c.src    = s;
        c.dst    = d;
        c.dst_en = 1'b1;
        return c;
    endfunction

    function automatic ctl_t alu_only(alu_op_e o);
        ctl_t c;
        c     = '0;
        c.alu = o;
        return c;
    endfunction

    always_comb begin
        unique case (cond_field)
            2'b00:   skip_hit = ac_neg;
            2'b01:   skip_hit = ac_zero;
            2'b10:   skip_hit = !ac_neg && !ac_zero;
            default: skip_hit = 1'b0;
        endcase
    end

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_A;
            step_q  <= K0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        step_d  = K0;
        unique case (state_q)
            ST_FETCH_A: state_d = ST_FETCH_B;
            ST_FETCH_B: state_d = ST_DECODE;
            ST_DECODE:  state_d = ST_EXEC;
            ST_EXEC: begin
                if (go_halt)      state_d = ST_HALT;
                else if (done)    state_d = ST_FETCH_A;
                else if (hold)    step_d  = step_q;
                else              step_d  = step_q + STEP_W'(1);
            end
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_FETCH_A;
        endcase
    end

    // per-step control word
    always_comb begin
        ctl     = '0;
        done    = 1'b0;
        go_halt = 1'b0;
        hold    = 1'b0;
        unique case (state_q)
            ST_FETCH_A: ctl = xfer(LOC_PC, LOC_MAR);
            ST_FETCH_B: begin
                ctl        = xfer(LOC_MEM, LOC_IR);
                ctl.pc_inc = 1'b1;
            end
            ST_DECODE:  ctl = xfer(LOC_IR, LOC_MAR);
            ST_EXEC: begin
                unique case (opc)
                    OP_JNS: begin
                        if (step_q == K0)      ctl = xfer(LOC_PC, LOC_MBR);
                        else if (step_q == K1) ctl = xfer(LOC_MBR, LOC_MEM);
                        else if (step_q == K2) ctl = xfer(LOC_IR, LOC_PC);
                        else begin
                            ctl.pc_inc = 1'b1;
                            done       = 1'b1;
                        end
                    end
                    OP_LOAD: begin
                        if (step_q == K0) ctl = xfer(LOC_MEM, LOC_MBR);
                        else begin
                            ctl  = xfer(LOC_MBR, LOC_AC);
                            done = 1'b1;
                        end
                    end
                    OP_STORE: begin
                        if (step_q == K0) ctl = xfer(LOC_AC, LOC_MBR);
                        else begin
                            ctl  = xfer(LOC_MBR, LOC_MEM);
                            done = 1'b1;
                        end
                    end
                    OP_ADD, OP_SUBT: begin
                        if (step_q == K0) ctl = xfer(LOC_MEM, LOC_MBR);
                        else begin
                            ctl  = alu_only(opc == OP_ADD ? ALU_ADD : ALU_SUB);
                            done = 1'b1;
                        end
                    end
                    OP_INPUT: begin
                        if (in_valid) begin
                            ctl  = xfer(LOC_IN, LOC_AC);
                            done = 1'b1;
                        end else begin
                            hold = 1'b1;
                        end
                        ctl.in_rdy = 1'b1;
                    end
                    OP_OUTPUT: begin
                        ctl  = xfer(LOC_AC, LOC_OUT);
                        done = 1'b1;
                    end
                    OP_HALT: go_halt = 1'b1;
                    OP_SKIP: begin
                        ctl.pc_inc = skip_hit;
                        done       = 1'b1;
                    end
                    OP_JUMP: begin
                        ctl  = xfer(LOC_IR, LOC_PC);
                        done = 1'b1;
                    end
                    OP_CLEAR: begin
                        ctl  = alu_only(ALU_CLR);
                        done = 1'b1;
                    end
                    OP_ADDI: begin
                        if (step_q == K0)      ctl = xfer(LOC_MEM, LOC_MBR);
                        else if (step_q == K1) ctl = xfer(LOC_MBR, LOC_MAR);
                        else if (step_q == K2) ctl = xfer(LOC_MEM, LOC_MBR);
                        else begin
                            ctl  = alu_only(ALU_ADD);
                            done = 1'b1;
                        end
                    end
                    OP_JUMPI: begin
                        if (step_q == K0) ctl = xfer(LOC_MEM, LOC_MBR);
                        else begin
                            ctl  = xfer(LOC_MBR, LOC_PC);
                            done = 1'b1;
                        end
                    end
                    default: done = 1'b1;
                endcase
            end
            default: ctl = '0;
        endcase
    end

    assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu import acc_pkg::*; #(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = MEM_AW,
    parameter int IO_W   = BYTE_W,
    parameter logic [ADDR_W-1:0] START_PC = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [DATA_W-1:0] pl_data,
    input  logic              in_valid,
    input  logic [IO_W-1:0]   in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [IO_W-1:0]   out_data,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] acc_out
);
    localparam int OPC_MSB  = DATA_W - 1;
    localparam int COND_MSB = ADDR_W - 1;

    ctl_t              ctl;
    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ac_q, mbr_q, ir_q;
    logic [IO_W-1:0]   out_q;
    logic              out_v_q;
    logic [DATA_W-1:0] bus, mem_rdata, alu_y, mem_wdata;
    logic [ADDR_W-1:0] mem_waddr;
    logic              mem_we;

    acc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_field   (ir_q[OPC_MSB -: 4]),
        .cond_field (ir_q[COND_MSB -: 2]),
        .ac_neg     (ac_q[DATA_W-1]),
        .ac_zero    (ac_q == '0),
        .in_valid   (in_valid),
        .ctl        (ctl),
        .halted     (halted)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ctl.alu),
        .a  (ac_q),
        .b  (mbr_q),
        .y  (alu_y)
    );

    assign mem_we    = !rst_n ? pl_we   : (ctl.dst_en && ctl.dst == LOC_MEM);
    assign mem_waddr = !rst_n ? pl_addr : mar_q;
    assign mem_wdata = !rst_n ? pl_data : bus;

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mar_q),
        .rdata (mem_rdata)
    );

    // shared bus source select
    always_comb begin
        unique case (ctl.src)
            LOC_MEM: bus = mem_rdata;
            LOC_MAR: bus = DATA_W'(mar_q);
            LOC_PC:  bus = DATA_W'(pc_q);
            LOC_MBR: bus = mbr_q;
            LOC_AC:  bus = ac_q;
            LOC_IN:  bus = DATA_W'(in_data);
            LOC_OUT: bus = DATA_W'(out_q);
            LOC_IR:  bus = ir_q;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= START_PC;
            mar_q   <= '0;
            ac_q    <= '0;
            mbr_q   <= '0;
            ir_q    <= '0;
            out_q   <= '0;
            out_v_q <= 1'b0;
        end else begin
            out_v_q <= 1'b0;
            if (ctl.pc_inc) pc_q <= pc_q + ADDR_W'(1);
            if (ctl.alu != ALU_NOP) ac_q <= alu_y;
            if (ctl.dst_en) begin
                case (ctl.dst)
                    LOC_MAR: mar_q <= bus[ADDR_W-1:0];
                    LOC_PC:  pc_q  <= bus[ADDR_W-1:0];
                    LOC_MBR: mbr_q <= bus;
                    LOC_AC:  ac_q  <= bus;
                    LOC_OUT: begin
                        out_q   <= bus[IO_W-1:0];
                        out_v_q <= 1'b1;
                    end
                    LOC_IR:  ir_q  <= bus;
                    default: ;
                endcase
            end
        end
    end

    assign in_ready  = ctl.in_rdy;
    assign out_valid = out_v_q;
    assign out_data  = out_q;
    assign pc_out    = pc_q;
    assign acc_out   = ac_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int IO_W   = 8,
    parameter logic [ADDR_W-1:0] START_PC = 'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [IO_W-1:0]   in_data,
    input logic              in_ready,
    input logic              out_valid,
    input logic [IO_W-1:0]   out_data,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_out,
    input logic [DATA_W-1:0] acc_out
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_out == START_PC && acc_out == '0 && !halted && !out_valid));

    assert_input_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> acc_out == DATA_W'($past(in_data)));

    assert_ready_not_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !halted);

    assert_out_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_out_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_data == $past(acc_out[IO_W-1:0]));

    assert_halt_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_out) && $stable(acc_out) && !out_valid));
endmodule

bind acc_cpu acc_cpu_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IO_W(IO_W), .START_PC(START_PC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .pc_out(pc_out), .acc_out(acc_out)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pl_we = 1'b0;
    logic [11:0] pl_addr = '0;
    logic [15:0] pl_data = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, halted;
    logic [7:0]  out_data;
    logic [11:0] pc_out;
    logic [15:0] acc_out;

    int checks = 0;
    int errors = 0;
    int out_count = 0;
    int out_base = 0;
    logic [7:0] last_out = '0;
    logic [7:0] prev_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu dut (
        .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .halted(halted),
        .pc_out(pc_out), .acc_out(acc_out)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            prev_out  <= last_out;
            last_out  <= out_data;
            out_count <= out_count + 1;
        end
    end

    // x, y, x+y, x-y
    localparam logic [15:0] ARITH [6][4] = '{
        '{16'h0005, 16'h0003, 16'h0008, 16'h0002},
        '{16'h7FFF, 16'h0001, 16'h8000, 16'h7FFE},
        '{16'h0000, 16'h0001, 16'h0001, 16'hFFFF},
        '{16'hFFFF, 16'hFFFF, 16'hFFFE, 16'h0000},
        '{16'h1234, 16'h0F0F, 16'h2143, 16'h0325},
        '{16'h8000, 16'h8000, 16'h0000, 16'h0000}
    };

    // accumulator value, skip instruction, final accumulator
    localparam logic [15:0] SKIPV [7][3] = '{
        '{16'hFFFB, 16'h8000, 16'hFFFB},
        '{16'h0000, 16'h8000, 16'h0077},
        '{16'h0000, 16'h8400, 16'h0000},
        '{16'h0005, 16'h8800, 16'h0005},
        '{16'hFFFF, 16'h8800, 16'h0077},
        '{16'h0005, 16'h8C00, 16'h0077},
        '{16'h0005, 16'h8400, 16'h0077}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        pl_we   = 1'b1;
        pl_addr = a;
        pl_data = d;
        @(negedge clk);
        pl_we   = 1'b0;
    endtask

    task automatic begin_prog();
        rst_n = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 'h140; a++) put(12'(a), 16'h0000);
        put(12'hFFF, 16'h0000);
        out_base = out_count;
    endtask

    task automatic run(input int limit);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < limit && !halted; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state, observed while reset is still held
        begin_prog();
        chk("R1 pc", pc_out, 32'h100);
        chk("R1 acc", acc_out, 0);
        chk("R1 flags", {halted, out_valid, in_ready}, 0);

        // R2 R3 table: store/reload and arithmetic
        for (int r = 0; r < 6; r++) begin
            begin_prog();
            put(12'h100, 16'h1110); put(12'h101, 16'h3111); put(12'h102, 16'h2112);
            put(12'h103, 16'h4111); put(12'h104, 16'h4111); put(12'h105, 16'h6000);
            put(12'h106, 16'h1112); put(12'h107, 16'h7000);
            put(12'h110, ARITH[r][0]); put(12'h111, ARITH[r][1]);
            run(300);
            chk("R2 R3 sum via store and reload", acc_out, ARITH[r][2]);
            chk("R3 difference byte R10", last_out, ARITH[r][3][7:0]);
            chk("R10 one output strobe", out_count - out_base, 1);
            chk("R11 halt pc", pc_out, 32'h108);
        end

        // R4 skip conditions
        for (int s = 0; s < 7; s++) begin
            begin_prog();
            put(12'h100, 16'h1110); put(12'h101, SKIPV[s][1]);
            put(12'h102, 16'h1111); put(12'h103, 16'h7000);
            put(12'h110, SKIPV[s][0]); put(12'h111, 16'h0077);
            run(300);
            chk("R4 skip result", acc_out, SKIPV[s][2]);
        end

        // R6 call/return through stored link
        begin_prog();
        put(12'h100, 16'h0120); put(12'h101, 16'h6000); put(12'h102, 16'h1120);
        put(12'h103, 16'h6000); put(12'h104, 16'h7000);
        put(12'h121, 16'h1130); put(12'h122, 16'hC120); put(12'h130, 16'h00A5);
        run(300);
        chk("R6 subroutine output", prev_out, 8'hA5);
        chk("R6 saved link", acc_out, 16'h0101);
        chk("R6 output count", out_count - out_base, 2);
        chk("R6 final pc", pc_out, 32'h105);

        // R5 jump and idle opcodes
        begin_prog();
        put(12'h100, 16'h1110); put(12'h101, 16'h9104); put(12'h102, 16'hA000);
        put(12'h103, 16'h7000); put(12'h104, 16'hD000); put(12'h105, 16'hF123);
        put(12'h106, 16'hE000); put(12'h107, 16'h7000); put(12'h110, 16'h4242);
        run(300);
        chk("R5 acc after idle opcodes", acc_out, 16'h4242);
        chk("R5 pc after jump", pc_out, 32'h108);
        chk("R5 no output", out_count - out_base, 0);

        // R7 indirect add
        begin_prog();
        put(12'h100, 16'h1110); put(12'h101, 16'hB111); put(12'h102, 16'h7000);
        put(12'h110, 16'h0010); put(12'h111, 16'h0115); put(12'h115, 16'h0020);
        run(300);
        chk("R7 indirect add", acc_out, 16'h0030);

        // R8 clear
        begin_prog();
        put(12'h100, 16'h1110); put(12'h101, 16'hA000); put(12'h102, 16'h7000);
        put(12'h110, 16'h8001);
        run(300);
        chk("R8 clear", acc_out, 0);

        // R9 input wait and capture
        begin_prog();
        put(12'h100, 16'h5000); put(12'h101, 16'h3110); put(12'h102, 16'h7000);
        put(12'h110, 16'h0100);
        run(20);
        chk("R9 waiting ready", {in_ready, halted}, 2'b10);
        chk("R9 acc held while waiting", acc_out, 0);
        in_valid = 1'b1;
        in_data  = 8'hC3;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        run(300);
        chk("R9 input then add", acc_out, 16'h01C3);

        // R12 wrap at top of memory
        begin_prog();
        put(12'h100, 16'h9FFF); put(12'hFFF, 16'h1010); put(12'h000, 16'h7000);
        put(12'h010, 16'h0BEE);
        run(300);
        chk("R12 wrapped fetch", acc_out, 16'h0BEE);
        chk("R12 pc after wrap", pc_out, 32'h001);

        // R11 frozen after halt
        begin
            logic [11:0] pc_hold;
            pc_hold = pc_out;
            repeat (10) @(negedge clk);
            chk("R11 pc frozen", pc_out, pc_hold);
            chk("R11 still halted", halted, 1);
            chk("R11 acc frozen", acc_out, 16'h0BEE);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule